// File: doc/BRIEF.md
# Fixed-Frame Serial Packet Host Sequencer

This block runs the host side of a reduced serial link in which every packet is exactly 32 bits. A command asks it to read from or write to one of sixteen targets. The block first sends a token. It then either sends or collects a frame of exactly eight data packets, and closes the exchange with a handshake. Write data comes from a transmit word FIFO, and read data goes into a receive word FIFO. Each packet crosses a bit-serial port, one bit per clock, to an external line coder. That coder handles line encoding and bit stuffing, so this block does neither.

Packets carry a 5-bit CRC, a 3-bit packet number and the target address. Received packets are checked for the sync pattern, the CRC and the packet number. A response that does not start within a fixed turn-around window ends the transfer with a timeout. After any transfer ends, the host keeps the line quiet for a guard interval before it sends the next token. On completion the start bit drops, and the status flags hold the outcome until the next command is accepted.

Top module: `pkt_host_link`

## Requirements
- R1: A packet goes out most significant bit first, one bit per clock, with `ser_tx_en_o` high for 32 consecutive cycles. Its layout is [31:28] sync = 4'b0001, [27:25] packet number, [24:21] target address, [20:5] 16-bit field, [4:0] CRC.
- R2: The CRC uses polynomial x^5+x^2+1 over bits [27:5], taken most significant first. The register starts at 5'b11111, and the packet carries the complement of the final register.
- R3: An accepted command first sends a token with packet number 0, the command's address, and field 16'h0009 for a read or 16'h000D for a write.
- R4: A write sends eight data packets after the token. They are numbered 0 to 7, and their fields are taken in order from the transmit FIFO. Sending stalls while the FIFO is empty.
- R5: A write ends when a response packet arrives. Field 16'h0002 (ACK) sets `ack_o`. Field 16'h000A (NACK) leaves `ack_o` at 0. A bad sync or bad CRC sets `err_crc_o` and leaves `ack_o` at 0.
- R6: A read accepts eight packets. A packet whose sync and CRC are good and whose number is as expected has its field pushed into the receive FIFO, in arrival order. A bad sync or bad CRC sets `err_crc_o`, and that word is dropped.
- R7: During a read, packets must be numbered 0 to 7 in order. A packet whose number differs from its position sets `err_seq_o`, and its word is dropped.
- R8: A read ends with a handshake packet sent by the host: number 0, field ACK if no error was flagged and NACK otherwise. `ack_o` is 1 exactly when ACK was sent.
- R9: If no response bit arrives within 18 bit times of the line going quiet, the transfer ends with `err_tmo_o` set, and the host sends no handshake.
- R10: On completion `busy_o` drops and `done_o` rises. Status is cleared when the next command is accepted. A command pulse while `busy_o` is high has no effect.
- R11: The first bit of a token is never sent earlier than 18 bit times after the previous transfer completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one bit time per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_go_i | input | 1 | Start pulse |
| cmd_wr_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | 4 | Target address |
| busy_o | output | 1 | Start bit, high until completion |
| done_o | output | 1 | Transfer completed |
| ack_o | output | 1 | Transfer closed with ACK |
| err_crc_o | output | 1 | Bad sync or CRC seen |
| err_seq_o | output | 1 | Packet number out of order |
| err_tmo_o | output | 1 | Response timeout |
| txf_push_i | input | 1 | Write a word into transmit FIFO |
| txf_data_i | input | 16 | Transmit FIFO word |
| txf_full_o | output | 1 | Transmit FIFO full |
| rxf_pop_i | input | 1 | Remove head of receive FIFO |
| rxf_data_o | output | 16 | Receive FIFO head word |
| rxf_empty_o | output | 1 | Receive FIFO empty |
| ser_tx_o | output | 1 | Serial transmit bit |
| ser_tx_en_o | output | 1 | Transmit bit valid |
| ser_rx_i | input | 1 | Serial receive bit |
| ser_rx_vld_i | input | 1 | Receive bit valid |

## Verification
The guard interval and a fresh start command meet in the cycle right after a completion. The bench pulses `cmd_go_i` as soon as it sees `done_o` after a timed-out transfer. It then measures the number of cycles until the token's first bit, and that gap must be at least 18. A second collision is a start pulse that arrives while a read is in flight. That pulse is judged by the read finishing normally and by the line staying silent afterwards.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  localparam logic [3:0]  SYNC     = 4'b0001;
  localparam logic [15:0] FN_READ  = 16'h0009;
  localparam logic [15:0] FN_WRITE = 16'h000D;
  localparam logic [15:0] HS_ACK   = 16'h0002;
  localparam logic [15:0] HS_NACK  = 16'h000A;

  typedef enum logic [2:0] {
    S_IDLE, S_TOK, S_WDATA, S_WLAST, S_RESP, S_RDATA, S_HSK, S_HEND
  } state_t;

  function automatic logic [4:0] crc5(input logic [22:0] d);
    logic [4:0] c;
    logic fb;
    c = 5'h1f;
    for (int i = 22; i >= 0; i--) begin
      fb = c[4] ^ d[i];
      c  = {c[3:0], 1'b0} ^ (fb ? 5'b00101 : 5'b00000);
    end
    return ~c;
  endfunction

  function automatic logic [31:0] make_pkt(input logic [2:0] num, input logic [3:0] addr,
                                           input logic [15:0] field);
    return {SYNC, num, addr, field, crc5({num, addr, field})};
  endfunction
endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) if (do_push) mem_q[wp_q] <= data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  // R4 / R6: occupancy stays within depth
  assert_fifo_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= (AW+1)'(DEPTH));
endmodule

// File: rtl/pkt_ser_tx.sv
module pkt_ser_tx #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic         idle_o,
  output logic         bit_o,
  output logic         en_o
);
  localparam int CW = $clog2(W+1);

  logic [W-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  assign idle_o = (cnt_q == '0);
  assign en_o   = !idle_o;
  assign bit_o  = sh_q[W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; cnt_q <= '0;
    end else if (load_i && idle_o) begin
      sh_q <= word_i; cnt_q <= CW'(W);
    end else if (!idle_o) begin
      sh_q <= {sh_q[W-2:0], 1'b0}; cnt_q <= cnt_q - 1'b1;
    end
  end

  // R1: a started packet is sent without gaps
  assert_tx_contig_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && cnt_q != CW'(1)) |=> en_o);
endmodule

// File: rtl/pkt_ser_rx.sv
module pkt_ser_rx #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  input  logic         vld_i,
  output logic [W-1:0] word_o,
  output logic         word_vld_o,
  output logic         active_o
);
  localparam int CW = $clog2(W);

  logic [W-2:0] sh_q;
  logic [CW-1:0] cnt_q;

  assign active_o = vld_i || (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; cnt_q <= '0; word_o <= '0; word_vld_o <= 1'b0;
    end else begin
      word_vld_o <= 1'b0;
      if (vld_i) begin
        sh_q  <= {sh_q[W-3:0], bit_i};
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(W-1)) begin
          word_o     <= {sh_q, bit_i};
          word_vld_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pkt_host_link.sv
module pkt_host_link
  import pkt_pkg::*;
#(
  parameter int TMO_BITS   = 18,
  parameter int GUARD_BITS = 18,
  parameter int FIFO_DEPTH = 8,
  parameter int FRAME_PKTS = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_go_i,
  input  logic        cmd_wr_i,
  input  logic [3:0]  cmd_addr_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        ack_o,
  output logic        err_crc_o,
  output logic        err_seq_o,
  output logic        err_tmo_o,
  input  logic        txf_push_i,
  input  logic [15:0] txf_data_i,
  output logic        txf_full_o,
  input  logic        rxf_pop_i,
  output logic [15:0] rxf_data_o,
  output logic        rxf_empty_o,
  output logic        ser_tx_o,
  output logic        ser_tx_en_o,
  input  logic        ser_rx_i,
  input  logic        ser_rx_vld_i
);
  localparam int TW   = $clog2(TMO_BITS + 1);
  localparam int GW   = $clog2(GUARD_BITS + 1);
  localparam logic [2:0] LAST = 3'(FRAME_PKTS - 1);

  state_t state_q;
  logic [2:0]  idx_q;
  logic [TW-1:0] tmo_q;
  logic [GW-1:0] guard_q;
  logic start_q, wr_q, done_q, ack_q, ecrc_q, eseq_q, etmo_q;
  logic [3:0] addr_q;

  logic tx_load, tx_idle, txf_pop, txf_empty, rxf_push;
  logic [31:0] tx_word, rx_word;
  logic rx_wv, rx_active, rx_ok;
  logic [15:0] txf_rdata;

  pkt_fifo #(.DW(16), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk_i, .rst_ni, .push_i(txf_push_i), .data_i(txf_data_i), .pop_i(txf_pop),
    .data_o(txf_rdata), .full_o(txf_full_o), .empty_o(txf_empty));

  pkt_fifo #(.DW(16), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk_i, .rst_ni, .push_i(rxf_push), .data_i(rx_word[20:5]), .pop_i(rxf_pop_i),
    .data_o(rxf_data_o), .full_o(), .empty_o(rxf_empty_o));

  pkt_ser_tx #(.W(32)) u_tx (
    .clk_i, .rst_ni, .load_i(tx_load), .word_i(tx_word), .idle_o(tx_idle),
    .bit_o(ser_tx_o), .en_o(ser_tx_en_o));

  pkt_ser_rx #(.W(32)) u_rx (
    .clk_i, .rst_ni, .bit_i(ser_rx_i), .vld_i(ser_rx_vld_i), .word_o(rx_word),
    .word_vld_o(rx_wv), .active_o(rx_active));

  assign rx_ok = (rx_word[31:28] == SYNC) && (crc5(rx_word[27:5]) == rx_word[4:0]);

  always_comb begin
    tx_load = 1'b0; tx_word = '0; txf_pop = 1'b0; rxf_push = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_q && guard_q == '0) begin
        tx_load = 1'b1;
        tx_word = make_pkt(3'd0, addr_q, wr_q ? FN_WRITE : FN_READ);
      end
      S_WDATA: if (tx_idle && !txf_empty) begin
        tx_load = 1'b1; txf_pop = 1'b1;
        tx_word = make_pkt(idx_q, addr_q, txf_rdata);
      end
      S_RDATA: rxf_push = rx_wv && rx_ok && (rx_word[27:25] == idx_q);
      S_HSK: begin
        tx_load = 1'b1;
        tx_word = make_pkt(3'd0, addr_q, (ecrc_q || eseq_q) ? HS_NACK : HS_ACK);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; idx_q <= '0; tmo_q <= '0; guard_q <= '0;
      start_q <= 1'b0; wr_q <= 1'b0; addr_q <= '0;
      done_q <= 1'b0; ack_q <= 1'b0; ecrc_q <= 1'b0; eseq_q <= 1'b0; etmo_q <= 1'b0;
    end else begin
      if (cmd_go_i && !start_q) begin
        start_q <= 1'b1; wr_q <= cmd_wr_i; addr_q <= cmd_addr_i;
        done_q <= 1'b0; ack_q <= 1'b0; ecrc_q <= 1'b0; eseq_q <= 1'b0; etmo_q <= 1'b0;
      end
      if (state_q == S_IDLE && guard_q != '0) guard_q <= guard_q - 1'b1;
      unique case (state_q)
        S_IDLE: if (tx_load) state_q <= S_TOK;
        S_TOK: if (tx_idle) begin
          idx_q <= '0; tmo_q <= '0;
          state_q <= wr_q ? S_WDATA : S_RDATA;
        end
        S_WDATA: if (tx_load) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST) state_q <= S_WLAST;
        end
        S_WLAST: if (tx_idle) begin tmo_q <= '0; state_q <= S_RESP; end
        S_RESP, S_RDATA: begin
          if (rx_wv) begin
            tmo_q <= '0;
            if (state_q == S_RESP) begin
              ecrc_q <= !rx_ok;
              ack_q  <= rx_ok && (rx_word[20:5] == HS_ACK);
              state_q <= S_IDLE; done_q <= 1'b1; start_q <= 1'b0;
              guard_q <= GW'(GUARD_BITS);
            end else begin
              if (!rx_ok) ecrc_q <= 1'b1;
              else if (rx_word[27:25] != idx_q) eseq_q <= 1'b1;
              idx_q <= idx_q + 1'b1;
              if (idx_q == LAST) state_q <= S_HSK;
            end
          end else if (!rx_active) begin
            if (tmo_q == TW'(TMO_BITS - 1)) begin
              etmo_q <= 1'b1; state_q <= S_IDLE; done_q <= 1'b1; start_q <= 1'b0;
              guard_q <= GW'(GUARD_BITS);
            end else tmo_q <= tmo_q + 1'b1;
          end
        end
        S_HSK: begin ack_q <= !(ecrc_q || eseq_q); state_q <= S_HEND; end
        S_HEND: if (tx_idle) begin
          state_q <= S_IDLE; done_q <= 1'b1; start_q <= 1'b0;
          guard_q <= GW'(GUARD_BITS);
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o    = start_q;
  assign done_o    = done_q;
  assign ack_o     = ack_q;
  assign err_crc_o = ecrc_q;
  assign err_seq_o = eseq_q;
  assign err_tmo_o = etmo_q;

  // R10: start bit only drops together with completion
  assert_done_on_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_q) |-> done_q);
  // R9: timeout only fires on a silent receive line
  assert_tmo_silent_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(etmo_q) |-> $past(!rx_active));
  // R5 / R8: ACK outcome never coexists with an error flag
  assert_ack_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> !(ack_q && (ecrc_q || eseq_q || etmo_q)));
  // R8: handshake only follows the read data phase
  assert_hsk_after_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HSK) |-> $past(state_q) == S_RDATA);
  // R11: no transmission starts inside the guard interval
  assert_guard_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ser_tx_en_o) |-> $past(guard_q) == '0);
endmodule

// File: tb/pkt_host_link_tb.sv
module pkt_host_link_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 0, wr = 0; logic [3:0] addr = 0;
  logic busy, done, ack, ecrc, eseq, etmo;
  logic txf_push = 0; logic [15:0] txf_data = 0; logic txf_full;
  logic rxf_pop = 0; logic [15:0] rxf_data; logic rxf_empty;
  logic stx, stx_en, srx = 0, srx_vld = 0;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pkt_host_link dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_go_i(go), .cmd_wr_i(wr), .cmd_addr_i(addr),
    .busy_o(busy), .done_o(done), .ack_o(ack), .err_crc_o(ecrc), .err_seq_o(eseq),
    .err_tmo_o(etmo), .txf_push_i(txf_push), .txf_data_i(txf_data), .txf_full_o(txf_full),
    .rxf_pop_i(rxf_pop), .rxf_data_o(rxf_data), .rxf_empty_o(rxf_empty),
    .ser_tx_o(stx), .ser_tx_en_o(stx_en), .ser_rx_i(srx), .ser_rx_vld_i(srx_vld));

  function automatic logic [4:0] ref_crc(input logic [22:0] d);
    logic [5:0] r = 6'h1f;
    for (int i = 22; i >= 0; i--) begin
      r = {r[4:0], 1'b0};
      if (r[5] ^ d[i]) r = r ^ 6'h25;
      r[5] = 1'b0;
    end
    return ~r[4:0];
  endfunction

  function automatic logic [31:0] pk(input logic [2:0] n, input logic [3:0] a, input logic [15:0] f);
    return {4'b0001, n, a, f, ref_crc({n, a, f})};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic get_pkt(output logic [31:0] w);
    int lim = 0; int gaps = 0;
    w = '0;
    while (!stx_en && lim < 4000) begin @(negedge clk); lim++; end
    for (int i = 0; i < 32; i++) begin
      if (!stx_en) gaps++;
      w = {w[30:0], stx};
      @(negedge clk);
    end
    check("R1 enable held 32 bits", gaps, 0);
  endtask

  task automatic put_pkt(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      srx_vld = 1'b1; srx = w[i]; @(negedge clk);
    end
    srx_vld = 1'b0; srx = 1'b0;
  endtask

  task automatic wait_done();
    int lim = 0;
    while (!done && lim < 4000) begin @(negedge clk); lim++; end
  endtask

  task automatic issue(input logic w, input logic [3:0] a);
    wr = w; addr = a; go = 1'b1; @(negedge clk); go = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 reset busy", busy, 0);
    check("R10 reset done", done, 0);
    check("R1 reset tx_en", stx_en, 0);
    check("R6 reset rx empty", rxf_empty, 1);
  endtask

  // resp: 0 ack, 1 nack, 2 bad crc
  task automatic t_write(input logic [3:0] a, input int resp);
    logic [31:0] w; logic [15:0] f;
    for (int i = 0; i < 8; i++) begin
      txf_push = 1; txf_data = 16'h1000 + 16'(i * 17) + {12'd0, a}; @(negedge clk);
    end
    txf_push = 0;
    issue(1'b1, a);
    get_pkt(w);
    check("R3 write token", w, pk(3'd0, a, 16'h000D));
    for (int i = 0; i < 8; i++) begin
      get_pkt(w);
      check("R4 R2 write data pkt", w, pk(3'(i), a, 16'h1000 + 16'(i * 17) + {12'd0, a}));
    end
    repeat (3) @(negedge clk);
    f = (resp == 1) ? 16'h000A : 16'h0002;
    w = pk(3'd0, a, f);
    if (resp == 2) w[0] = ~w[0];
    put_pkt(w);
    wait_done();
    check("R10 write done", done, 1);
    check("R10 write busy clear", busy, 0);
    check("R5 write ack", ack, (resp == 0));
    check("R5 write crc err", ecrc, (resp == 2));
  endtask

  // bad: -1 none; kind 0 crc flip, 1 wrong number
  task automatic t_read(input logic [3:0] a, input int bad, input int kind, input logic poke);
    logic [31:0] w; int n = 0;
    issue(1'b0, a);
    get_pkt(w);
    check("R3 read token", w, pk(3'd0, a, 16'h0009));
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      w = pk(3'(i), a, 16'hA000 + 16'(i * 3));
      if (i == bad && kind == 0) w[2] = ~w[2];
      if (i == bad && kind == 1) w = pk(3'(i + 1), a, 16'hA000 + 16'(i * 3));
      if (poke && i == 2) begin wr = 1; addr = 4'hF; go = 1; end
      put_pkt(w);
      go = 0;
      repeat (2) @(negedge clk);
    end
    get_pkt(w);
    check("R8 handshake", w, pk(3'd0, a, (bad < 0) ? 16'h0002 : 16'h000A));
    wait_done();
    check("R8 read ack", ack, (bad < 0));
    check("R6 read crc flag", ecrc, (bad >= 0 && kind == 0));
    check("R7 read seq flag", eseq, (bad >= 0 && kind == 1));
    for (int i = 0; i < 8; i++) begin
      if (i != bad) begin
        check("R6 rx fifo word", {rxf_empty, rxf_data}, {1'b0, 16'hA000 + 16'(i * 3)});
        n++;
        rxf_pop = 1; @(negedge clk); rxf_pop = 0;
      end
    end
    check("R6 rx fifo drained", rxf_empty, 1);
    if (poke) begin
      int seen = 0;
      for (int i = 0; i < 80; i++) begin if (stx_en || busy) seen++; @(negedge clk); end
      check("R10 go while busy ignored", seen, 0);
    end
  endtask

  task automatic t_timeout_guard();
    logic [31:0] w; int gap = 0; int seen = 0;
    for (int i = 0; i < 8; i++) begin
      txf_push = 1; txf_data = 16'(i); @(negedge clk);
    end
    txf_push = 0;
    issue(1'b1, 4'h3);
    for (int i = 0; i < 9; i++) get_pkt(w);
    wait_done();
    check("R9 timeout flag", etmo, 1);
    check("R9 timeout no ack", ack, 0);
    issue(1'b0, 4'h6);
    check("R10 status cleared on go", {done, etmo}, 2'b00);
    while (!stx_en && gap < 200) begin @(negedge clk); gap++; end
    check("R11 guard gap >= 18", (gap + 1 >= 18), 1);
    get_pkt(w);
    check("R3 token after guard", w, pk(3'd0, 4'h6, 16'h0009));
    wait_done();
    check("R9 read timeout flag", etmo, 1);
    for (int i = 0; i < 30; i++) begin if (stx_en) seen++; @(negedge clk); end
    check("R9 no handshake after timeout", seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(4'h5, 0);
    t_write(4'hA, 1);
    t_write(4'h2, 2);
    t_read(4'h7, -1, 0, 1'b1);
    t_read(4'h4, 3, 0, 1'b0);
    t_read(4'h9, 5, 1, 1'b0);
    t_timeout_guard();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule